// File: doc/BRIEF.md
# Audio Transmit Controller Register Block

This block is the register side of a serial audio transmitter. A host reaches it through a simple port that carries a valid strobe, a write flag, a word index and 32 bits of data. Behind that port sit a fixed identification word, a configuration register, a two-bit interrupt mask and a two-bit event status register. Four write-only data ports complete the map. Each write to any data port pushes one 32-bit sample word into an internal transmit FIFO. The serializer drains that FIFO one word per `smp_pop` pulse and reads its settings from the configuration fields brought out as ports.

Two events are tracked. The underrun event is the FIFO being empty. The level event is the fill count being below a trip point. The trip point is half the FIFO depth shifted right by a 4-bit level-select field. Each event is latched into a status bit. The bit stays set until the host writes a 1 to it. If the event still holds at that point, the bit sets again on the next edge. A single interrupt line is raised when the global interrupt-enable bit is set and at least one latched, unmasked event is present.

The FIFO depth is a parameter and must be a power of two. The nominal depth is 8192 words; the default is 64 so that simulation stays small. A write to a full FIFO is lost, and a sticky overflow indicator records the loss.

Top module: `atx_reg_block`

## Requirements
- R1: After reset the configuration register and the mask read 0, `irq` is low, `smp_avail` is low and `ovf_flag` is low.
- R2: The word index selects the register as follows: 0 is the identification word (byte offset 0x00), 1 is configuration (0x04), 2 is the mask (0x08), 3 is the status (0x0C), and 4 to 7 are the data ports (0x10 to 0x1C). Reading index 0 returns the `VERSION_WORD` parameter, and writes to index 0 leave it unchanged. Reading indices 4 to 7 returns 0.
- R3: The configuration bit positions are as follows: bit 0 is transmit enable, bit 1 is interrupt enable, bit 2 is left-first, [15:8] is the clock ratio, [21:16] is the sample resolution, [27:24] is the level select and [31:28] is the channel field. Bits [7:3] and [23:22] always read 0. The stored fields drive the matching output ports, and the register changes only when it is written.
- R4: Each write to any of word indices 4 to 7 appends its data to the FIFO. `smp_data` shows the oldest word while `smp_avail` is high, and a `smp_pop` pulse advances to the next word in write order.
- R5: A data write while the FIFO already holds `FIFO_DEPTH` words is dropped. The fill count is left unchanged and `ovf_flag` is set and stays set until reset.
- R6: The level condition holds when the fill count is less than (`FIFO_DEPTH`/2) >> level select. It is latched into status bit 1.
- R7: The underrun condition holds when the fill count is 0. It is latched into status bit 0.
- R8: A status bit stays 1 after its condition ends. Writing 1 to that bit at index 3 clears it, and it is set again on the next edge if its condition still holds. Writing 0 to a bit has no effect on it.
- R9: The mask register keeps only bits [1:0], which use the same bit positions as the status register; its other bits read 0. `irq` is 1 exactly when configuration bit 1 is set and (status AND mask) is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |
| tx_enable | output | 1 | Configuration bit 0 |
| left_first | output | 1 | Configuration bit 2 |
| clk_ratio | output | 8 | Configuration bits [15:8] |
| sample_bits | output | 6 | Configuration bits [21:16] |
| level_sel | output | 4 | Configuration bits [27:24] |
| chan_field | output | 4 | Configuration bits [31:28] |
| smp_pop | input | 1 | Serializer takes the head word |
| smp_data | output | 32 | Head word of the FIFO |
| smp_avail | output | 1 | FIFO holds at least one word |
| ovf_flag | output | 1 | Sticky: a data write was lost to a full FIFO |

## Verification
The bench fills a 16-word FIFO one word at a time, from empty to full. At every fill count it tries all sixteen level-select codes and clears the status before reading it. Comparing the read value against the arithmetic trip point separates an off-by-one at the `<` boundary from a wrong shift direction, and separates the empty case from the merely low case. The interrupt line is swept over every enable and mask combination while the status is 00, 10 and 11, which exposes any missing gate or swapped bit. The drain phase checks word order and the lost write past full. The latch phase shows that events persist, that writing 0 leaves them alone and that each bit clears on its own.

// File: rtl/atx_pkg.sv
package atx_pkg;

  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_VER  = 3'd0,
    IDX_CFG  = 3'd1,
    IDX_MASK = 3'd2,
    IDX_STAT = 3'd3,
    IDX_DAT0 = 3'd4,
    IDX_DAT1 = 3'd5,
    IDX_DAT2 = 3'd6,
    IDX_DAT3 = 3'd7
  } reg_idx_e;

  localparam int EVT_UNDER = 0;
  localparam int EVT_LEVEL = 1;
  localparam int EVT_N     = 2;

  typedef struct packed {
    logic [3:0] chan;
    logic [3:0] lvl;
    logic [1:0] pad_hi;
    logic [5:0] res;
    logic [7:0] ratio;
    logic [4:0] pad_lo;
    logic       left;
    logic       ien;
    logic       ten;
  } cfg_t;

  function automatic cfg_t cfg_from_word(input logic [31:0] w);
    cfg_t c;
    c        = cfg_t'(w);
    c.pad_hi = '0;
    c.pad_lo = '0;
    return c;
  endfunction

  function automatic logic level_low(input int unsigned fill,
                                     input int unsigned half_depth,
                                     input logic [3:0]  sel);
    return fill < (half_depth >> sel);
  endfunction

  function automatic logic is_data_idx(input logic [IDX_W-1:0] idx);
    return idx[IDX_W-1];
  endfunction

endpackage

// File: rtl/atx_sample_fifo.sv
module atx_sample_fifo #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  fill,
  output logic              full,
  output logic              empty,
  output logic              ovf_sticky
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              push_ok, pop_ok, push_drop;

  assign full      = (fill == CNT_W'(DEPTH));
  assign empty     = (fill == '0);
  assign push_ok   = push_req && !full;
  assign push_drop = push_req && full;
  assign pop_ok    = pop_req && !empty;
  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      fill       <= '0;
      ovf_sticky <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (push_drop) ovf_sticky <= 1'b1;
    end
  end

  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH)); // R5
  AST_DROP_HOLDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop && !pop_req |=> $stable(fill)); // R5
  AST_OVF_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_sticky |=> ovf_sticky); // R5
  AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovf_sticky); // R5

endmodule

// File: rtl/atx_event_status.sv
module atx_event_status #(
  parameter int N_EVT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] cond,
  input  logic [N_EVT-1:0] clr,
  input  logic [N_EVT-1:0] mask,
  input  logic             irq_en,
  output logic [N_EVT-1:0] stat,
  output logic             irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr) | cond;
  end

  assign irq = irq_en && |(stat & mask);

  for (genvar b = 0; b < N_EVT; b++) begin : g_evt
    AST_COND_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      cond[b] |=> stat[b]); // R6
    AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      stat[b] && !clr[b] |=> stat[b]); // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      clr[b] && !cond[b] |=> !stat[b]); // R8
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R9

endmodule

// File: rtl/atx_reg_block.sv
module atx_reg_block
  import atx_pkg::*;
#(
  parameter int          FIFO_DEPTH   = 64,
  parameter int          DATA_W       = 32,
  parameter logic [31:0] VERSION_WORD = 32'h0001_0200,
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1,
  localparam int HALF  = FIFO_DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              tx_enable,
  output logic              left_first,
  output logic [7:0]        clk_ratio,
  output logic [5:0]        sample_bits,
  output logic [3:0]        level_sel,
  output logic [3:0]        chan_field,
  input  logic              smp_pop,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_avail,
  output logic              ovf_flag
);

  cfg_t             cfg_q;
  logic [EVT_N-1:0] mask_q;
  logic [EVT_N-1:0] evt_cond, evt_clr, evt_stat;
  logic [CNT_W-1:0] fill;
  logic             fifo_full, fifo_empty;

  // named access events
  logic wr_hit, wr_cfg, wr_mask, wr_stat, wr_data;
  assign wr_hit  = bus_valid && bus_write;
  assign wr_cfg  = wr_hit && (bus_addr == IDX_CFG);
  assign wr_mask = wr_hit && (bus_addr == IDX_MASK);
  assign wr_stat = wr_hit && (bus_addr == IDX_STAT);
  assign wr_data = wr_hit && is_data_idx(bus_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_cfg)  cfg_q  <= cfg_from_word(bus_wdata);
      if (wr_mask) mask_q <= bus_wdata[EVT_N-1:0];
    end
  end

  atx_sample_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (wr_data),
    .push_data  (bus_wdata[DATA_W-1:0]),
    .pop_req    (smp_pop),
    .head_data  (smp_data),
    .fill       (fill),
    .full       (fifo_full),
    .empty      (fifo_empty),
    .ovf_sticky (ovf_flag)
  );

  always_comb begin
    evt_cond            = '0;
    evt_cond[EVT_UNDER] = fifo_empty;
    evt_cond[EVT_LEVEL] = level_low(32'(fill), HALF, cfg_q.lvl);
    evt_clr             = wr_stat ? bus_wdata[EVT_N-1:0] : '0;
  end

  atx_event_status #(.N_EVT(EVT_N)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond   (evt_cond),
    .clr    (evt_clr),
    .mask   (mask_q),
    .irq_en (cfg_q.ien),
    .stat   (evt_stat),
    .irq    (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IDX_VER:  bus_rdata = VERSION_WORD;
      IDX_CFG:  bus_rdata = cfg_q;
      IDX_MASK: bus_rdata = 32'(mask_q);
      IDX_STAT: bus_rdata = 32'(evt_stat);
      default:  bus_rdata = '0;
    endcase
  end

  assign tx_enable   = cfg_q.ten;
  assign left_first  = cfg_q.left;
  assign clk_ratio   = cfg_q.ratio;
  assign sample_bits = cfg_q.res;
  assign level_sel   = cfg_q.lvl;
  assign chan_field  = cfg_q.chan;
  assign smp_avail   = !fifo_empty;

  AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(cfg_q)); // R3
  AST_UNDERRUN_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_avail |=> evt_stat[EVT_UNDER]); // R7
  AST_FULL_NEVER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && cfg_q.lvl == '0 |-> !evt_cond[EVT_LEVEL]); // R6

endmodule

// File: tb/sim_atx_reg_block.sv
module sim_atx_reg_block;

  localparam int          DEPTH = 16;
  localparam logic [31:0] VER   = 32'h0003_0701;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, tx_enable, left_first;
  logic [7:0]  clk_ratio;
  logic [5:0]  sample_bits;
  logic [3:0]  level_sel, chan_field;
  logic        smp_pop = 1'b0;
  logic [31:0] smp_data;
  logic        smp_avail, ovf_flag;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  atx_reg_block #(.FIFO_DEPTH(DEPTH), .VERSION_WORD(VER)) u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_stat(int fill, int sel);
    logic lvl;
    lvl = fill < ((DEPTH / 2) >> sel);
    return {30'd0, lvl, fill == 0};
  endfunction

  task automatic pop_check(logic [31:0] exp);
    @(negedge clk);
    chk("R4 head word", smp_data, exp);
    smp_pop = 1;
    @(negedge clk);
    smp_pop = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(3'd1, r); chk("R1 cfg reset", r, 0);
    rd(3'd2, r); chk("R1 mask reset", r, 0);
    chk("R1 irq reset", irq, 0);
    chk("R1 avail reset", smp_avail, 0);
    chk("R1 ovf reset", ovf_flag, 0);

    // R2 map
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, r); chk("R2 version fixed", r, VER);
    for (int i = 4; i < 8; i++) begin
      rd(3'(i), r); chk("R2 data port reads 0", r, 0);
    end

    // R3 config fields
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, r); chk("R3 cfg reserved bits zero", r, 32'hFF3F_FF07);
    wr(3'd1, 32'h5A2B_C305);
    rd(3'd1, r); chk("R3 cfg readback", r, 32'h5A2B_C305);
    chk("R3 fields", {chan_field, level_sel, sample_bits, clk_ratio, tx_enable, left_first},
        {4'h5, 4'hA, 6'h2B, 8'hC3, 1'b1, 1'b1});
    wr(3'd4, 32'h1234_5678);
    rd(3'd1, r); chk("R3 cfg unchanged by other write", r, 32'h5A2B_C305);
    pop_check(32'h1234_5678);

    // R9 mask width
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, r); chk("R9 mask keeps two bits", r, 3);
    wr(3'd2, 0);

    // R6 R7 sweep over fill count and level select
    for (int n = 0; n <= DEPTH; n++) begin
      if (n > 0) wr(3'(4 + (n - 1) % 4), 32'hA500_0000 + n - 1);
      chk("R4 avail", smp_avail, n != 0);
      for (int s = 0; s < 16; s++) begin
        wr(3'd1, s << 24);
        wr(3'd3, 3);
        rd(3'd3, r);
        chk($sformatf("R6 R7 status fill=%0d sel=%0d", n, s), r, exp_stat(n, s));
      end
    end

    // R5 overflow
    chk("R5 ovf before", ovf_flag, 0);
    wr(3'd5, 32'hDEAD_BEEF);
    chk("R5 ovf set", ovf_flag, 1);
    for (int i = 0; i < DEPTH; i++) pop_check(32'hA500_0000 + i);
    chk("R5 dropped word absent", smp_avail, 0);
    chk("R5 ovf sticky", ovf_flag, 1);

    // R8 latching
    wr(3'd1, 0);
    for (int i = 0; i < 9; i++) wr(3'd6, i);
    rd(3'd3, r); chk("R8 events persist", r, 3);
    wr(3'd3, 0);
    rd(3'd3, r); chk("R8 write 0 no effect", r, 3);
    wr(3'd3, 1);
    rd(3'd3, r); chk("R8 clear bit0 only", r, 2);
    wr(3'd3, 2);
    rd(3'd3, r); chk("R8 clear bit1", r, 0);

    // R9 irq with status 00
    for (int e = 0; e < 2; e++)
      for (int m = 0; m < 4; m++) begin
        wr(3'd1, e << 1); wr(3'd2, m);
        @(negedge clk); chk($sformatf("R9 irq st=00 en=%0d m=%0d", e, m), irq, 0);
      end
    for (int i = 0; i < 9; i++) pop_check(i);
    // status now 11
    for (int e = 0; e < 2; e++)
      for (int m = 0; m < 4; m++) begin
        wr(3'd1, e << 1); wr(3'd2, m);
        @(negedge clk);
        chk($sformatf("R9 irq st=11 en=%0d m=%0d", e, m), irq, (e == 1) && (m != 0));
      end
    wr(3'd7, 32'h77);
    wr(3'd3, 3);
    rd(3'd3, r); chk("R8 reassert level", r, 2);
    for (int e = 0; e < 2; e++)
      for (int m = 0; m < 4; m++) begin
        wr(3'd1, e << 1); wr(3'd2, m);
        @(negedge clk);
        chk($sformatf("R9 irq st=10 en=%0d m=%0d", e, m), irq, (e == 1) && (m >= 2));
      end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule